// File: doc/BRIEF.md
# Turn-Synchronous Timing Message Broadcaster

This block runs from the bunch clock and divides it down to one pulse per machine revolution. Each revolution it takes a snapshot of the running time base, the turn count and a small set of host-supplied bytes. It shifts that snapshot out as a fixed-length serial frame, most significant bit first, a fixed number of cycles after the turn pulse. Downstream stages such as line encoding and optical transmission receive the serial bit stream, a valid flag and a start flag.

The host places its parameter bytes in a staging register with a write strobe. Staged values move into the frame source only on the clock edge that ends a revolution, so a frame never mixes old and new settings. A test-byte mode lets the host put a known byte into every frame, so that a receiver can check what it gets. The time base counts bunch-clock periods inside the current second. A once-per-second input pulse clears that count and advances a seconds counter.

Top module: `turn_msg_bcast`

## Requirements
- R1: `turn_mark_o` is a one-cycle pulse once every TURN_LEN (default 3564) clock cycles. The first pulse comes in cycle TURN_LEN after reset release, counting the first clock edge with `rst_n` high as cycle 1.
- R2: `turn_count_o` is a 32-bit counter, 0 after reset. It rises by one, modulo 2^32, in the cycle where `turn_mark_o` is high, and is stable otherwise.
- R3: Each frame is 128 contiguous bits on `ser_data_o` with `ser_valid_o` high. The first bit appears START_OFS (default 8) cycles after the `turn_mark_o` cycle, and `ser_start_o` is high with the first bit only.
- R4: The frame is sent MSB first. Its bytes, in order, are: sync byte 0xA5, turn count (4 bytes), seconds (4 bytes), sub-second count (4 bytes), status byte, mode byte, test byte. Multi-byte fields are sent most significant byte first.
- R5: The turn-count field equals the `turn_count_o` value seen in that turn's marker cycle.
- R6: The seconds field counts `pps_i` pulses since reset. The sub-second field counts clock edges from the last `pps_i` edge, or from reset, up to the marker cycle. A clock edge where `pps_i` is high clears the sub-second count to 0 and increments the seconds count.
- R7: A `host_wr_i` edge copies `host_status_i`, `host_mode_i`, `host_test_i` and `host_test_en_i` into staging. Staged values appear in the first frame whose marker follows the next revolution end, so a write after a marker leaves that turn's frame unchanged. Input changes without `host_wr_i` have no effect.
- R8: When the applied test enable is 1, the test-byte field is the applied `host_test_i`. When it is 0, the field is 0x00.
- R9: While `rst_n` is low, and after it is released, `turn_mark_o`, `ser_valid_o`, `ser_start_o` and `turn_count_o` are 0. Staged and applied host values return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pps_i | input | 1 | Once-per-second pulse, one cycle |
| host_wr_i | input | 1 | Staging write strobe |
| host_status_i | input | 8 | Status byte to stage |
| host_mode_i | input | 8 | Mode byte to stage |
| host_test_i | input | 8 | Test byte to stage |
| host_test_en_i | input | 1 | Test-byte enable to stage |
| turn_mark_o | output | 1 | Revolution pulse |
| turn_count_o | output | 32 | Current turn count |
| ser_data_o | output | 1 | Serial frame bit |
| ser_valid_o | output | 1 | Serial bit valid |
| ser_start_o | output | 1 | First bit of frame |

## Verification
The bench writes host parameters two cycles after a marker. It expects the frame already snapshotted for that turn to keep the old bytes and the next frame to carry the new ones. A design that loaded the frame source straight from the inputs would tear that frame, and one that ignored the strobe would change bytes without a write. It pulses the one-second input between frames and checks that the seconds field steps and the sub-second field restarts from the pulse edge. An off-by-one clear would shift that field by one. It also measures the exact marker period, the delay from marker to the first serial bit and the frame length. It toggles the test-byte enable both ways, and resets in mid-run to confirm that the turn count and the host bytes return to zero.

// File: rtl/tmb_pkg.sv
// Shared constants and types for the turn message broadcaster.
// Assumes a fixed 16-byte frame layout; field widths are fixed by that layout.
package tmb_pkg;
    localparam int TURN_W      = 32;
    localparam int SEC_W       = 32;
    localparam int SUB_W       = 32;
    localparam int FRAME_BYTES = 16;
    localparam int FRAME_BITS  = FRAME_BYTES * 8;
    localparam logic [7:0] SYNC_BYTE = 8'hA5;

    typedef struct packed {
        logic [7:0] status;
        logic [7:0] mode;
        logic [7:0] test;
        logic       test_en;
    } host_cfg_t;
endpackage

// File: rtl/tmb_rev_div.sv
// Revolution divider: counts buckets 0..TURN_LEN-1. It flags the last bucket
// (turn_end_o), registers a one-cycle marker and keeps the turn counter.
// Assumes TURN_LEN >= 2.
module tmb_rev_div #(
    parameter int TURN_LEN = 3564
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic                      turn_end_o,
    output logic                      mark_o,
    output logic [tmb_pkg::TURN_W-1:0] turn_o
);
    localparam int CNT_W = $clog2(TURN_LEN);

    logic [CNT_W-1:0] bucket_q;

    assign turn_end_o = (bucket_q == CNT_W'(TURN_LEN - 1));

    // Bucket counter, marker register and turn counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bucket_q <= '0;
            mark_o   <= 1'b0;
            turn_o   <= '0;
        end else begin
            bucket_q <= turn_end_o ? '0 : bucket_q + CNT_W'(1);
            mark_o   <= turn_end_o;
            if (turn_end_o) begin
                turn_o <= turn_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmb_time_base.sv
// Time base: a sub-second counter in clock periods and a seconds counter.
// A pps pulse clears the sub-second count and advances the seconds count.
// Assumes pps_i is already synchronous to clk.
module tmb_time_base (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pps_i,
    output logic [tmb_pkg::SEC_W-1:0] secs_o,
    output logic [tmb_pkg::SUB_W-1:0] sub_o
);
    // Count periods and roll over on the second pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secs_o <= '0;
            sub_o  <= '0;
        end else if (pps_i) begin
            secs_o <= secs_o + 1'b1;
            sub_o  <= '0;
        end else begin
            sub_o  <= sub_o + 1'b1;
        end
    end
endmodule

// File: rtl/tmb_param_buf.sv
// Double buffer for host bytes. The strobe writes staging, and the end of a
// revolution copies staging into the applied set, so each frame sees one set.
module tmb_param_buf (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  tmb_pkg::host_cfg_t cfg_i,
    input  logic               load_i,
    output tmb_pkg::host_cfg_t cfg_o
);
    tmb_pkg::host_cfg_t stage_q;

    // Staging write and turn-aligned transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            cfg_o   <= '0;
        end else begin
            if (wr_i) begin
                stage_q <= cfg_i;
            end
            if (load_i) begin
                cfg_o <= stage_q;
            end
        end
    end
endmodule

// File: rtl/tmb_frame_ser.sv
// Frame snapshot and serializer. It captures all fields on the marker, waits
// START_OFS cycles from the marker, then shifts FRAME_BITS out MSB first.
// Assumes START_OFS >= 2 and a revolution longer than START_OFS+FRAME_BITS.
module tmb_frame_ser #(
    parameter int START_OFS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mark_i,
    input  logic [tmb_pkg::TURN_W-1:0] turn_i,
    input  logic [tmb_pkg::SEC_W-1:0]  secs_i,
    input  logic [tmb_pkg::SUB_W-1:0]  sub_i,
    input  tmb_pkg::host_cfg_t         cfg_i,
    output logic                       ser_data_o,
    output logic                       ser_valid_o,
    output logic                       ser_start_o
);
    localparam int FB     = tmb_pkg::FRAME_BITS;
    localparam int BIT_W  = $clog2(FB);
    localparam int WAIT_W = $clog2(START_OFS + 1);

    logic [FB-1:0]     snap_q;
    logic [FB-1:0]     shreg_q;
    logic [7:0]        test_byte;
    logic              waiting_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic              sending_q;
    logic [BIT_W-1:0]  bitcnt_q;

    // Test-byte field: host byte in test mode, zero otherwise.
    assign test_byte = cfg_i.test_en ? cfg_i.test : 8'h00;

    // Snapshot of every field, taken on the marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (mark_i) begin
            snap_q <= {tmb_pkg::SYNC_BYTE, turn_i, secs_i, sub_i,
                       cfg_i.status, cfg_i.mode, test_byte};
        end
    end

    // Start-delay counting and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
            wcnt_q    <= '0;
            sending_q <= 1'b0;
            bitcnt_q  <= '0;
            shreg_q   <= '0;
        end else if (mark_i) begin
            waiting_q <= 1'b1;
            wcnt_q    <= WAIT_W'(1);
            sending_q <= 1'b0;
        end else if (waiting_q && wcnt_q == WAIT_W'(START_OFS - 1)) begin
            waiting_q <= 1'b0;
            sending_q <= 1'b1;
            bitcnt_q  <= '0;
            shreg_q   <= snap_q;
        end else begin
            if (waiting_q) begin
                wcnt_q <= wcnt_q + WAIT_W'(1);
            end
            if (sending_q) begin
                shreg_q  <= shreg_q << 1;
                bitcnt_q <= bitcnt_q + BIT_W'(1);
                if (bitcnt_q == BIT_W'(FB - 1)) begin
                    sending_q <= 1'b0;
                end
            end
        end
    end

    assign ser_data_o  = sending_q & shreg_q[FB-1];
    assign ser_valid_o = sending_q;
    assign ser_start_o = sending_q && (bitcnt_q == '0);
endmodule

// File: rtl/turn_msg_bcast.sv
// Top level: turn-synchronous timing message broadcaster. It ties together
// the divider, time base, host double buffer and frame serializer.
// Assumes all inputs are synchronous to the bunch clock.
module turn_msg_bcast #(
    parameter int TURN_LEN  = 3564,
    parameter int START_OFS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pps_i,
    input  logic        host_wr_i,
    input  logic [7:0]  host_status_i,
    input  logic [7:0]  host_mode_i,
    input  logic [7:0]  host_test_i,
    input  logic        host_test_en_i,
    output logic        turn_mark_o,
    output logic [31:0] turn_count_o,
    output logic        ser_data_o,
    output logic        ser_valid_o,
    output logic        ser_start_o
);
    logic                       turn_end;
    logic [tmb_pkg::SEC_W-1:0]  secs;
    logic [tmb_pkg::SUB_W-1:0]  sub;
    tmb_pkg::host_cfg_t         cfg_in;
    tmb_pkg::host_cfg_t         cfg_app;

    assign cfg_in = '{status: host_status_i, mode: host_mode_i,
                      test: host_test_i, test_en: host_test_en_i};

    tmb_rev_div #(.TURN_LEN(TURN_LEN)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .turn_end_o (turn_end),
        .mark_o     (turn_mark_o),
        .turn_o     (turn_count_o)
    );

    tmb_time_base u_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .pps_i  (pps_i),
        .secs_o (secs),
        .sub_o  (sub)
    );

    tmb_param_buf u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (host_wr_i),
        .cfg_i  (cfg_in),
        .load_i (turn_end),
        .cfg_o  (cfg_app)
    );

    tmb_frame_ser #(.START_OFS(START_OFS)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .mark_i      (turn_mark_o),
        .turn_i      (turn_count_o),
        .secs_i      (secs),
        .sub_i       (sub),
        .cfg_i       (cfg_app),
        .ser_data_o  (ser_data_o),
        .ser_valid_o (ser_valid_o),
        .ser_start_o (ser_start_o)
    );
endmodule

// File: rtl/turn_msg_bcast_chk.sv
// Checker for the broadcaster's port timing, bound to the top module.
module turn_msg_bcast_chk #(
    parameter int TURN_LEN  = 3564,
    parameter int START_OFS = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        turn_mark_o,
    input logic [31:0] turn_count_o,
    input logic        ser_valid_o,
    input logic        ser_start_o
);
    int gap_q;
    int since_q;
    int run_q;

    // Cycle distance from the previous marker, or from reset.
    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= 0;
        else        gap_q <= turn_mark_o ? 1 : gap_q + 1;
    end

    // Cycles since the last marker, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_q <= 1 << 20;
        else if (turn_mark_o)      since_q <= 1;
        else if (since_q < (1 << 20)) since_q <= since_q + 1;
    end

    // Length of the current valid run.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 0;
        else        run_q <= ser_valid_o ? run_q + 1 : 0;
    end

    AST_MARK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) turn_mark_o |-> gap_q == TURN_LEN); // R1
    AST_MARK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) turn_mark_o |=> !turn_mark_o); // R1
    AST_TURN_STEP: assert property (@(posedge clk) disable iff (!rst_n) turn_mark_o |-> turn_count_o == $past(turn_count_o) + 32'd1); // R2
    AST_TURN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !turn_mark_o |-> $stable(turn_count_o)); // R2
    AST_START_DELAY: assert property (@(posedge clk) disable iff (!rst_n) ser_start_o |-> since_q == START_OFS); // R3
    AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n) ser_start_o |-> ser_valid_o); // R3
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(ser_valid_o) |-> run_q == tmb_pkg::FRAME_BITS); // R3
endmodule

bind turn_msg_bcast turn_msg_bcast_chk #(.TURN_LEN(TURN_LEN), .START_OFS(START_OFS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .turn_mark_o  (turn_mark_o),
    .turn_count_o (turn_count_o),
    .ser_valid_o  (ser_valid_o),
    .ser_start_o  (ser_start_o)
);

// File: tb/turn_msg_bcast_tb.sv
// Directed bench for the turn message broadcaster.
module turn_msg_bcast_tb;
    localparam int TURN_LEN  = 3564;
    localparam int START_OFS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pps_i = 1'b0;
    logic        host_wr_i = 1'b0;
    logic [7:0]  host_status_i = 8'h00;
    logic [7:0]  host_mode_i = 8'h00;
    logic [7:0]  host_test_i = 8'h00;
    logic        host_test_en_i = 1'b0;
    logic        turn_mark_o;
    logic [31:0] turn_count_o;
    logic        ser_data_o;
    logic        ser_valid_o;
    logic        ser_start_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int marks = 0;
    int last_mark_cyc = 0;
    int last_pps_cyc = 0;
    int exp_secs = 0;
    int frames = 0;
    int nbits = 0;
    logic [127:0] rx_sh = '0;
    logic [127:0] rx_frame = '0;
    logic [7:0] exp_status = 0, exp_mode = 0, exp_test = 0;

    always #2 clk = ~clk;

    turn_msg_bcast #(.TURN_LEN(TURN_LEN), .START_OFS(START_OFS)) u_dut (
        .clk(clk), .rst_n(rst_n), .pps_i(pps_i), .host_wr_i(host_wr_i),
        .host_status_i(host_status_i), .host_mode_i(host_mode_i),
        .host_test_i(host_test_i), .host_test_en_i(host_test_en_i),
        .turn_mark_o(turn_mark_o), .turn_count_o(turn_count_o),
        .ser_data_o(ser_data_o), .ser_valid_o(ser_valid_o), .ser_start_o(ser_start_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Edge counter since reset release.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Port monitor: marker spacing, turn count and serial capture.
    always @(negedge clk) begin
        if (!rst_n) begin
            marks = 0; last_mark_cyc = 0; nbits = 0;
        end else begin
            if (turn_mark_o) begin
                marks++;
                chk(cyc - last_mark_cyc == TURN_LEN, "R1 marker period", cyc - last_mark_cyc, TURN_LEN);
                chk(turn_count_o == marks, "R2 turn count at marker", turn_count_o, marks);
                last_mark_cyc = cyc;
            end
            if (ser_valid_o) begin
                if (ser_start_o) begin
                    nbits = 0;
                    chk(cyc - last_mark_cyc == START_OFS, "R3 start delay", cyc - last_mark_cyc, START_OFS);
                end
                rx_sh = {rx_sh[126:0], ser_data_o};
                nbits++;
                if (nbits == 128) begin
                    rx_frame = rx_sh;
                    frames++;
                end
            end
        end
    end

    task automatic wait_frame();
        int f = frames;
        while (frames == f) @(negedge clk);
    endtask

    task automatic wait_mark();
        int m = marks;
        while (marks == m) @(negedge clk);
    endtask

    // Compare a received frame against the bench's expectations.
    task automatic check_frame();
        chk(rx_frame[127:120] == 8'hA5, "R4 sync byte", rx_frame[127:120], 8'hA5);
        chk(rx_frame[119:88] == marks, "R5 turn field", rx_frame[119:88], marks);
        chk(rx_frame[87:56] == exp_secs, "R6 seconds field", rx_frame[87:56], exp_secs);
        chk(rx_frame[55:24] == last_mark_cyc - last_pps_cyc, "R6 sub-second field",
            rx_frame[55:24], last_mark_cyc - last_pps_cyc);
        chk(rx_frame[23:16] == exp_status, "R7 status byte", rx_frame[23:16], exp_status);
        chk(rx_frame[15:8] == exp_mode, "R7 mode byte", rx_frame[15:8], exp_mode);
        chk(rx_frame[7:0] == exp_test, "R8 test byte", rx_frame[7:0], exp_test);
    endtask

    // Write host bytes two cycles after a marker; check old then new frame.
    task automatic host_write(input logic [7:0] st, input logic [7:0] md,
                              input logic [7:0] tb, input logic ten);
        wait_mark();
        @(negedge clk);
        host_status_i = st; host_mode_i = md; host_test_i = tb; host_test_en_i = ten;
        host_wr_i = 1'b1;
        @(negedge clk);
        host_wr_i = 1'b0;
        wait_frame();
        check_frame();
        exp_status = st; exp_mode = md; exp_test = ten ? tb : 8'h00;
        wait_frame();
        check_frame();
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(turn_mark_o == 0, "R9 marker in reset", turn_mark_o, 0);
        chk(ser_valid_o == 0, "R9 valid in reset", ser_valid_o, 0);
        chk(ser_start_o == 0, "R9 start in reset", ser_start_o, 0);
        chk(turn_count_o == 0, "R9 turn count in reset", turn_count_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(turn_count_o == 0, "R9 turn count after reset", turn_count_o, 0);
    endtask

    task automatic t_plain_frames();
        wait_frame(); check_frame();
        wait_frame(); check_frame();
    endtask

    task automatic t_pps();
        // one pulse between frames
        @(negedge clk);
        pps_i = 1'b1; last_pps_cyc = cyc + 1; exp_secs++;
        @(negedge clk);
        pps_i = 1'b0;
        wait_frame(); check_frame();
        // two pulses in one turn
        repeat (100) @(negedge clk);
        pps_i = 1'b1; exp_secs++;
        @(negedge clk);
        pps_i = 1'b0;
        repeat (500) @(negedge clk);
        pps_i = 1'b1; last_pps_cyc = cyc + 1; exp_secs++;
        @(negedge clk);
        pps_i = 1'b0;
        wait_frame(); check_frame();
    endtask

    task automatic t_dbuf();
        host_write(8'h5A, 8'h03, 8'h77, 1'b0);
        // inputs change with no strobe: R7 no effect
        @(negedge clk);
        host_status_i = 8'hFF; host_mode_i = 8'hEE;
        wait_frame(); check_frame();
        wait_frame(); check_frame();
    endtask

    task automatic t_test_byte();
        host_write(8'h11, 8'h22, 8'h3C, 1'b1);
        host_write(8'h11, 8'h22, 8'hC3, 1'b0);
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(turn_count_o == 0, "R9 turn count after mid reset", turn_count_o, 0);
        chk(ser_valid_o == 0, "R9 valid after mid reset", ser_valid_o, 0);
        host_status_i = 8'h00; host_mode_i = 8'h00; host_test_i = 8'h00; host_test_en_i = 1'b0;
        exp_status = 0; exp_mode = 0; exp_test = 0; exp_secs = 0; last_pps_cyc = 0;
        rst_n = 1'b1;
        wait_frame(); check_frame();
    endtask

    initial begin
        t_reset();
        t_plain_frames();
        t_pps();
        t_dbuf();
        t_test_byte();
        t_mid_reset();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end
endmodule